// File: doc/BRIEF.md
# H-Bridge Control and Fault Sequencer

This block is the digital core of a single-channel brushed-DC H-bridge driver. Two control inputs select coast, forward, reverse or brake. An active-low sleep input parks the bridge. Three digital fault flags come from the analog side: supply undervoltage, a current-limit flag for each of the four FETs, and over-temperature. The block drives four gate enables, one high-side and one low-side for each half-bridge, and a high-impedance indication for each output.

All asynchronous inputs pass through two-flop synchronizers. Leaving sleep starts a wake delay before the bridge follows its inputs. A current-limit flag must persist beyond a deglitch window before it shuts the bridge down. After such a shutdown a retry timer keeps every FET off, and operation then resumes without help. Undervoltage and over-temperature disable the bridge only while they are present.

Every turn-on inside a half-bridge waits for a dead time with both of its FETs off. The deglitch, retry and wake windows are derived from a clock-frequency parameter: 1 µs, 1 ms and 30 µs. All pins are plain control and status levels. No data stream passes through the block, so no port has a valid/ready handshake.

Top module: `hbridge_seq`

## Requirements
- R1: With the sleep input low, all four gate enables are 0 and both high-impedance indications are 1, whatever the control inputs are. Reset gives the same output state, with fault code 0.
- R2: When awake and fault-free, control inputs (a,b) select the outputs as follows. 00 leaves both outputs high-impedance. 10 drives output 1 high (gate_hs_o[0]) and output 2 low (gate_ls_o[1]). 01 drives output 1 low (gate_ls_o[0]) and output 2 high (gate_hs_o[1]). 11 drives both low-side gates. Index 0 of every 2-bit output is output 1.
- R3: After the synchronized sleep input rises, the bridge stays off for WAKE_CYC cycles (30 µs) before it follows the control inputs.
- R4: A current-limit flag that is high for no more than DEG_CYC synchronized cycles (1 µs) has no effect. One held longer shuts the bridge down.
- R5: After an overcurrent shutdown, all FETs stay off for RETRY_CYC cycles (1 ms), and then the bridge resumes on its own.
- R6: While the undervoltage flag is high, all FETs are off. The bridge resumes once the flag clears.
- R7: While the over-temperature flag is high, all FETs are off. The bridge resumes once the flag clears.
- R8: fault_o encodes the fault that is disabling the bridge: 0 none, 1 undervoltage, 2 over-temperature, 3 overcurrent retry. Priority is overcurrent, then undervoltage, then over-temperature.
- R9: The high-side and low-side FETs of one leg are never on together. A FET turns on only after its leg has had both FETs off for at least DEAD_CYC cycles.
- R10: Sleep cancels a running retry timer. A fault during the wake delay cancels that delay, and the bridge then stays off until the sleep input rises again.
- R11: Any of the four bits of ilim_i can cause the overcurrent shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_n_i | input | 1 | Active-low sleep request |
| in_a_i | input | 1 | Control input for output 1 |
| in_b_i | input | 1 | Control input for output 2 |
| uv_flag_i | input | 1 | Supply undervoltage flag |
| ilim_i | input | 4 | Per-FET current-limit flags |
| ot_flag_i | input | 1 | Over-temperature flag |
| gate_hs_o | output | 2 | High-side gate enables, index per output |
| gate_ls_o | output | 2 | Low-side gate enables, index per output |
| hiz_o | output | 2 | Output is high-impedance |
| fault_o | output | 2 | Active fault code |

## Verification
The hardest state to reach is a fault that lands inside the wake delay. The bench puts the sleep input through a low-high edge, waits well short of the wake window, and then pulses the over-temperature flag. It then checks that the bridge stays off far beyond the wake time until a second sleep edge. A similar sequence reaches an overcurrent retry that the sleep input cuts short. It trips the shutdown with a held current-limit flag and toggles sleep within the 1 ms window. The bench then checks that the bridge returns after only the wake delay.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UV   = 2'd1,
    FLT_OT   = 2'd2,
    FLT_OC   = 2'd3
  } flt_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/hb_fault.sv
module hb_fault
  import hb_pkg::*;
#(
  parameter int DEG_CYC   = 10,
  parameter int RETRY_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slp_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic [3:0] ilim_i,
  output flt_e       fault_o
);
  localparam int DGW = $clog2(DEG_CYC + 1);
  localparam int RTW = $clog2(RETRY_CYC + 1);

  logic           ilim_any;
  logic [DGW-1:0] dg_cnt;
  logic [RTW-1:0] rt_cnt;
  logic           retry_run;
  flt_e           fault_d;

  assign ilim_any = |ilim_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dg_cnt    <= '0;
      rt_cnt    <= '0;
      retry_run <= 1'b0;
    end else if (!slp_i) begin
      dg_cnt    <= '0;
      rt_cnt    <= '0;
      retry_run <= 1'b0;
    end else if (retry_run) begin
      dg_cnt <= '0;
      if (rt_cnt == RTW'(RETRY_CYC - 1)) begin
        retry_run <= 1'b0;
        rt_cnt    <= '0;
      end else begin
        rt_cnt <= rt_cnt + 1'b1;
      end
    end else if (ilim_any) begin
      if (dg_cnt == DGW'(DEG_CYC)) begin
        retry_run <= 1'b1;
        dg_cnt    <= '0;
      end else begin
        dg_cnt <= dg_cnt + 1'b1;
      end
    end else begin
      dg_cnt <= '0;
    end
  end

  always_comb begin
    if (retry_run)  fault_d = FLT_OC;
    else if (uv_i)  fault_d = FLT_UV;
    else if (ot_i)  fault_d = FLT_OT;
    else            fault_d = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_o <= FLT_NONE;
    else        fault_o <= fault_d;
  end

  // R4: a trip always follows at least two cycles of a live flag
  p_trip_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_run) |-> ($past(ilim_any) && $past(ilim_any, 2)));
  // R10: sleep ends any retry window
  p_sleep_kills_retry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_i |=> (fault_o != FLT_OC) || !retry_run);
endmodule

// File: rtl/hb_wake.sv
module hb_wake #(
  parameter int WAKE_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slp_i,
  input  logic flt_i,
  output logic awake_o
);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic          slp_d;
  logic          run_q;
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_d   <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      awake_o <= 1'b0;
    end else begin
      slp_d <= slp_i;
      if (!slp_i) begin
        run_q   <= 1'b0;
        cnt_q   <= '0;
        awake_o <= 1'b0;
      end else if (!slp_d) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (flt_i) begin
          run_q <= 1'b0;
        end else if (cnt_q == WW'(WAKE_CYC - 1)) begin
          run_q   <= 1'b0;
          awake_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R1: the awake state never outlives the sleep input by more than a cycle
  p_awake_needs_slp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    awake_o |-> $past(slp_i));
  // R3: waking requires the sleep input held high
  p_wake_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake_o) |-> ($past(slp_i) && $past(slp_i, 2)));
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hs_i,
  input  logic want_ls_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic [DW-1:0] off_cnt;
  logic          hs_d, ls_d;

  always_comb begin
    hs_d = 1'b0;
    ls_d = 1'b0;
    if (!want_hs_i && !want_ls_i) begin
      hs_d = 1'b0;
      ls_d = 1'b0;
    end else if ((hs_o && want_hs_i) || (ls_o && want_ls_i)) begin
      hs_d = hs_o;
      ls_d = ls_o;
    end else if (!hs_o && !ls_o && off_cnt == DW'(DEAD_CYC)) begin
      hs_d = want_hs_i;
      ls_d = want_ls_i && !want_hs_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o    <= 1'b0;
      ls_o    <= 1'b0;
      off_cnt <= '0;
    end else begin
      hs_o <= hs_d;
      ls_o <= ls_d;
      if (hs_o || ls_o)                 off_cnt <= '0;
      else if (off_cnt != DW'(DEAD_CYC)) off_cnt <= off_cnt + 1'b1;
    end
  end

  // R9: no shoot-through, and each turn-on follows an off cycle of the partner
  p_leg_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_o && ls_o));
  p_hs_after_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> !$past(ls_o));
  p_ls_after_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_o) |-> !$past(hs_o));
endmodule

// File: rtl/hbridge_seq.sv
module hbridge_seq
  import hb_pkg::*;
#(
  parameter int CLK_HZ   = 10_000_000,
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n_i,
  input  logic       in_a_i,
  input  logic       in_b_i,
  input  logic       uv_flag_i,
  input  logic [3:0] ilim_i,
  input  logic       ot_flag_i,
  output logic [1:0] gate_hs_o,
  output logic [1:0] gate_ls_o,
  output logic [1:0] hiz_o,
  output logic [1:0] fault_o
);
  localparam int DEG_CYC   = CLK_HZ / 1_000_000;
  localparam int RETRY_CYC = CLK_HZ / 1000;
  localparam int WAKE_CYC  = (CLK_HZ / 1_000_000) * 30;
  localparam int NSYNC     = 9;

  logic [NSYNC-1:0] raw, syn;
  logic             slp_s, a_s, b_s, uv_s, ot_s;
  logic [3:0]       ilim_s;
  flt_e             flt;
  logic             awake, bridge_en;

  assign raw = {sleep_n_i, in_a_i, in_b_i, uv_flag_i, ot_flag_i, ilim_i};
  assign {slp_s, a_s, b_s, uv_s, ot_s, ilim_s} = syn;

  hb_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  hb_fault #(.DEG_CYC(DEG_CYC), .RETRY_CYC(RETRY_CYC)) u_fault (
    .clk(clk), .rst_n(rst_n), .slp_i(slp_s), .uv_i(uv_s), .ot_i(ot_s),
    .ilim_i(ilim_s), .fault_o(flt)
  );

  hb_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .slp_i(slp_s), .flt_i(flt != FLT_NONE),
    .awake_o(awake)
  );

  assign bridge_en = awake && (flt == FLT_NONE);

  for (genvar k = 0; k < 2; k++) begin : g_leg
    logic own, other;
    assign own   = (k == 0) ? a_s : b_s;
    assign other = (k == 0) ? b_s : a_s;
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .want_hs_i(bridge_en && own && !other),
      .want_ls_i(bridge_en && other),
      .hs_o(gate_hs_o[k]), .ls_o(gate_ls_o[k])
    );
    assign hiz_o[k] = !(gate_hs_o[k] || gate_ls_o[k]);
  end

  assign fault_o = flt;

  // R3: nothing conducts in the cycle after the bridge is not awake
  p_asleep_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> (gate_hs_o == 2'b00) && (gate_ls_o == 2'b00));
  // R6: any reported fault blocks all gates one cycle later
  p_fault_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt != FLT_NONE) |=> (gate_hs_o == 2'b00) && (gate_ls_o == 2'b00));
endmodule

// File: tb/hbridge_seq_tb.sv
module hbridge_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000_000;
  localparam int DEAD       = 4;
  localparam int DEG        = CLK_HZ / 1_000_000;
  localparam int RETRY      = CLK_HZ / 1000;
  localparam int WAKE       = DEG * 30;
  localparam int NV         = 11;

  // {slp, a, b, uv, ot, hs[1:0], ls[1:0], fault[1:0]}
  localparam logic [10:0] VEC [NV] = '{
    11'b1_00_00_00_00_00, // R2 coast
    11'b1_10_00_01_10_00, // R2 forward
    11'b1_01_00_10_01_00, // R2 reverse
    11'b1_11_00_00_11_00, // R2 brake
    11'b1_10_10_00_00_01, // R6 undervoltage
    11'b1_10_00_01_10_00, // R6 resume
    11'b1_01_01_00_00_10, // R7 over-temperature
    11'b1_01_11_00_00_01, // R8 uv over ot
    11'b1_01_00_10_01_00, // R7 resume
    11'b0_10_00_00_00_00, // R1 sleep forward
    11'b0_11_00_00_00_00  // R1 sleep brake
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_n = 1'b0, in_a = 1'b0, in_b = 1'b0, uv = 1'b0, ot = 1'b0;
  logic [3:0] ilim = 4'b0;
  logic [1:0] hs, ls, hiz, flt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hbridge_seq #(.CLK_HZ(CLK_HZ), .DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_n_i(sleep_n), .in_a_i(in_a),
    .in_b_i(in_b), .uv_flag_i(uv), .ilim_i(ilim), .ot_flag_i(ot),
    .gate_hs_o(hs), .gate_ls_o(ls), .hiz_o(hiz), .fault_o(flt)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] ehs, input logic [1:0] els,
                     input logic [1:0] ef);
    logic [7:0] act, exp;
    act = {hs, ls, hiz, flt};
    exp = {ehs, els, ~(ehs | els), ef};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act hs/ls/hiz/flt=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 reset state", 2'b00, 2'b00, 2'b00);
    rst_n = 1'b1;
    sleep_n = 1'b1;
    tick(WAKE + 40);

    for (int i = 0; i < NV; i++) begin
      {sleep_n, in_a, in_b, uv, ot} = VEC[i][10:6];
      tick(40);
      chk($sformatf("R2/R6/R7/R8/R1 vector %0d", i), VEC[i][5:4], VEC[i][3:2], VEC[i][1:0]);
    end

    // R3 wake delay from sleep
    in_a = 1'b1; in_b = 1'b0;
    sleep_n = 1'b1;
    tick(WAKE - 10);
    chk("R3 still off inside wake", 2'b00, 2'b00, 2'b00);
    tick(30);
    chk("R3 forward after wake", 2'b01, 2'b10, 2'b00);

    // R4 short pulse ignored
    ilim[0] = 1'b1;
    tick(DEG - 2);
    ilim[0] = 1'b0;
    tick(20);
    chk("R4 short pulse ignored", 2'b01, 2'b10, 2'b00);

    // R11/R5 long flag on bit 3 trips, then retry
    ilim[3] = 1'b1;
    tick(DEG + 10);
    ilim[3] = 1'b0;
    chk("R11 ilim[3] trips", 2'b00, 2'b00, 2'b11);
    tick(RETRY - 120);
    chk("R5 off during retry", 2'b00, 2'b00, 2'b11);
    tick(170);
    chk("R5 resumes after retry", 2'b01, 2'b10, 2'b00);

    // R8 overcurrent reported over undervoltage, R10 sleep cancels retry
    ilim[1] = 1'b1;
    tick(DEG + 10);
    ilim[1] = 1'b0;
    uv = 1'b1;
    tick(20);
    chk("R8 oc over uv", 2'b00, 2'b00, 2'b11);
    uv = 1'b0;
    tick(10);
    sleep_n = 1'b0;
    tick(20);
    sleep_n = 1'b1;
    tick(WAKE + 30);
    chk("R10 sleep cancels retry", 2'b01, 2'b10, 2'b00);

    // R10 fault inside wake cancels wake
    sleep_n = 1'b0;
    tick(20);
    sleep_n = 1'b1;
    tick(100);
    ot = 1'b1;
    tick(20);
    ot = 1'b0;
    tick(WAKE + 100);
    chk("R10 wake cancelled by fault", 2'b00, 2'b00, 2'b00);
    sleep_n = 1'b0;
    tick(20);
    sleep_n = 1'b1;
    tick(WAKE + 30);
    chk("R10 wake after new edge", 2'b01, 2'b10, 2'b00);

    // R9 dead time on reversal, leg 0
    begin
      int  gap = 0;
      int  min_gap = 1000;
      bit  overlap = 1'b0;
      bit  seen_off = 1'b0;
      in_a = 1'b0; in_b = 1'b1;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (hs[0] && ls[0]) overlap = 1'b1;
        if (!hs[0] && !ls[0]) begin
          gap++;
          seen_off = 1'b1;
        end else if (seen_off && ls[0] && gap > 0) begin
          if (gap < min_gap) min_gap = gap;
          gap = 0;
        end
      end
      chk_bit("R9 no overlap", overlap, 1'b0);
      chk_bit("R9 dead time respected", (min_gap >= DEAD) && (min_gap != 1000), 1'b1);
      chk("R9 reverse reached", 2'b10, 2'b01, 2'b00);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule